// File: doc/BRIEF.md
# Write-Policy Selectable Data Cache Controller

This block sits between a load/store port and a word-addressed backing memory and keeps a set-associative array of data blocks. Each slot holds a tag, a valid bit and a dirty bit. The line size is one, two or four words. A static mode pin selects the store policy. In write-through mode every store leaves memory up to date. In write-back mode stores stay in the cache and mark the slot dirty until it is evicted. The block does no victim selection of its own. The requester supplies a way index with each request, and that way is used whenever the lookup misses.

The requester's port is valid/ready. A request must stay stable while `req_valid` is high and `req_ready` is low. It is taken in a cycle where both are high. `req_ready` is high only while the controller is idle. Completion is a single-cycle `rsp_done` pulse, and for loads `rsp_rdata` holds the word during that pulse.

The memory side has three streams:
- A command stream carries a direction and the base word address of the block.
- A write-beat stream sends the words of an outgoing block in ascending order.
- A read-beat stream receives the words of an incoming block in ascending order.

Every stream may be back-pressured at any beat. The controller holds a command until it is accepted. It holds each write beat until `mem_wd_ready` is high. It takes a read beat only while `mem_rd_ready` is high. Only one burst is in flight at a time.

Top module: `wcd_dcache`

## Requirements
- R1: During and after reset the controller is idle: `req_ready` is 1, `rsp_done` is 0, and no memory command, write beat or read readiness is asserted.
- R2: Each accepted request produces exactly one single-cycle `rsp_done` pulse. `req_ready` is 1 during that pulse, so a new request can be taken in the same cycle.
- R3: A load that hits in any way of its set returns the stored word and causes no memory command.
- R4: A load miss, and a store miss when a line holds more than one word, fetches the whole enclosing block. The read command carries the block base address (word address with the offset bits cleared), followed by one read beat per word, before the access completes.
- R5: In write-through mode a store hit updates the word in the slot and then writes the entire updated line to memory as one write command at the block base. `rsp_done` follows the last write beat.
- R6: In write-through mode a store miss fetches the block, merges the stored word into it, and then writes the entire line to memory.
- R7: In write-back mode a store marks the slot dirty, and a store hit makes no memory command.
- R8: In write-back mode a load or store miss whose victim slot is valid and dirty first writes the old line to the old line's block address. It then fetches the new block (unless R10 applies) and then performs the access.
- R9: In write-back mode a miss on an invalid or clean victim writes nothing back and only fetches the block.
- R10: With one-word lines a store never issues a read command. It overwrites word 0 of the slot. In write-through mode it also writes that word to memory.
- R11: A hit in any way of the set is served from that way whatever `req_way` says. On a miss the slot selected by `req_way` is replaced.
- R12: A memory command stays asserted and unchanged until accepted. A write beat keeps its data until accepted. The write-beat stream and read readiness are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wback_en | input | 1 | Policy select: 1 write-back, 0 write-through; change only while idle after reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_we | input | 1 | 1 store, 0 load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | WORD_W | Store data |
| req_way | input | WAY_W | Way to replace on a miss |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | WORD_W | Load data, valid with `rsp_done` |
| mem_cmd_valid | output | 1 | Memory block command valid |
| mem_cmd_ready | input | 1 | Memory command accepted |
| mem_cmd_we | output | 1 | 1 block write, 0 block read |
| mem_cmd_addr | output | ADDR_W | Block base word address |
| mem_wd_valid | output | 1 | Write beat valid |
| mem_wd_ready | input | 1 | Write beat accepted |
| mem_wd_data | output | WORD_W | Write beat data |
| mem_rd_valid | input | 1 | Read beat valid |
| mem_rd_ready | output | 1 | Controller takes read beats |
| mem_rd_data | input | WORD_W | Read beat data |

## Verification
The completion pulse of one request and the acceptance of the next can land in the same cycle. The bench raises the next request in the very cycle `rsp_done` is seen, for the instance that finishes last. It then judges the overlap by requiring `req_ready` during that pulse, exactly one pulse per request, and correct data and memory traffic for the request taken in that cycle.

A write-back eviction and the fetch that follows share a miss. A conflict-heavy address sweep, with memory stalls injected on every stream, makes dirty victims common. Later loads of evicted addresses must then return the values written back.

// File: rtl/wcd_pkg.sv
package wcd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_FILL,
    ST_ACCESS,
    ST_MWRITE
  } ctl_state_e;

  // Index width that never collapses to zero bits.
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wcd_tag_store.sv
module wcd_tag_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int TAG_W = 4,
  parameter int SET_W = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [WAY_W-1:0] sel_way_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic             sel_valid_o,
  output logic             sel_dirty_o,
  output logic [TAG_W-1:0] sel_tag_o,
  input  logic             wr_en_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             wr_dirty_i
);

  localparam int ENTRIES = SETS * WAYS;
  localparam int ENT_W   = wcd_pkg::idx_bits(ENTRIES);

  function automatic logic [ENT_W-1:0] slot(input logic [WAY_W-1:0] w,
                                            input logic [SET_W-1:0] s);
    return ENT_W'(int'(w) * SETS + int'(s));
  endfunction

  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] dirty_q;
  logic [WAYS-1:0]    match;
  logic [ENT_W-1:0]   sel_slot;
  logic [ENT_W-1:0]   wr_slot;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    localparam logic [WAY_W-1:0] WID = WAY_W'(w);
    assign match[w] = valid_q[slot(WID, set_i)] && (tag_q[slot(WID, set_i)] == tag_i);
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) hit_way_o = WAY_W'(w);
    end
  end

  assign hit_o       = |match;
  assign sel_slot    = slot(sel_way_i, set_i);
  assign sel_valid_o = valid_q[sel_slot];
  assign sel_dirty_o = dirty_q[sel_slot];
  assign sel_tag_o   = tag_q[sel_slot];
  assign wr_slot     = slot(wr_way_i, set_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_slot] <= 1'b1;
      dirty_q[wr_slot] <= wr_dirty_i;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) tag_q[wr_slot] <= wr_tag_i;
  end

endmodule

// File: rtl/wcd_data_store.sv
module wcd_data_store #(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int BLK    = 4,
  parameter int WORD_W = 32,
  parameter int SET_W  = 2,
  parameter int WAY_W  = 1,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic [SET_W-1:0]  set_i,
  input  logic [WAY_W-1:0]  rd_way_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [WORD_W-1:0] rd_word_o,
  input  logic              wr_en_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [WORD_W-1:0] wr_word_i
);

  localparam int DEPTH = SETS * WAYS * BLK;
  localparam int DEP_W = wcd_pkg::idx_bits(DEPTH);

  function automatic logic [DEP_W-1:0] loc(input logic [WAY_W-1:0] w,
                                           input logic [SET_W-1:0] s,
                                           input logic [OFF_W-1:0] o);
    int off;
    off = (BLK > 1) ? int'(o) : 0;
    return DEP_W'((int'(w) * SETS + int'(s)) * BLK + off);
  endfunction

  logic [WORD_W-1:0] word_q [DEPTH];

  assign rd_word_o = word_q[loc(rd_way_i, set_i, rd_off_i)];

  always_ff @(posedge clk) begin
    if (wr_en_i) word_q[loc(wr_way_i, set_i, wr_off_i)] <= wr_word_i;
  end

endmodule

// File: rtl/wcd_dcache.sv
module wcd_dcache #(
  parameter int ADDR_W    = 8,
  parameter int WORD_W    = 32,
  parameter int SETS      = 4,
  parameter int WAYS      = 2,
  parameter int BLK_WORDS = 4,
  localparam int WAY_W    = wcd_pkg::idx_bits(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wback_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [WAY_W-1:0]  req_way,
  output logic              rsp_done,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic              mem_cmd_we,
  output logic [ADDR_W-1:0] mem_cmd_addr,
  output logic              mem_wd_valid,
  input  logic              mem_wd_ready,
  output logic [WORD_W-1:0] mem_wd_data,
  input  logic              mem_rd_valid,
  output logic              mem_rd_ready,
  input  logic [WORD_W-1:0] mem_rd_data
);
  import wcd_pkg::*;

  localparam int SET_W = $clog2(SETS);
  localparam int OFF_N = $clog2(BLK_WORDS);
  localparam int OFF_W = idx_bits(BLK_WORDS);
  localparam int TAG_W = ADDR_W - OFF_N - SET_W;
  localparam bit ONE_WORD = (BLK_WORDS == 1);

  function automatic logic [ADDR_W-1:0] block_base(input logic [TAG_W-1:0] t,
                                                   input logic [SET_W-1:0] s);
    return ADDR_W'((int'(t) * SETS + int'(s)) * BLK_WORDS);
  endfunction

  ctl_state_e        state;
  logic [ADDR_W-1:0] a_addr;
  logic              a_we;
  logic [WORD_W-1:0] a_wdata;
  logic [WAY_W-1:0]  a_way;
  logic [WAY_W-1:0]  tgt_q;
  logic [OFF_W-1:0]  cnt;
  logic              cmd_sent;
  logic              done_q;
  logic [WORD_W-1:0] rdata_q;

  logic [OFF_W-1:0]  a_off;
  logic [SET_W-1:0]  a_set;
  logic [TAG_W-1:0]  a_tag;
  logic              cnt_last;

  logic              hit;
  logic [WAY_W-1:0]  hit_way;
  logic [WAY_W-1:0]  sel_way;
  logic              sel_valid;
  logic              sel_dirty;
  logic [TAG_W-1:0]  sel_tag;
  logic              tw_en;
  logic              tw_dirty;

  logic [OFF_W-1:0]  rd_off;
  logic [WORD_W-1:0] rd_word;
  logic              dw_en;
  logic [OFF_W-1:0]  dw_off;
  logic [WORD_W-1:0] dw_word;

  logic              cmd_fire;
  logic              wd_fire;
  logic              rd_fire;

  // Address split
  assign a_off    = OFF_W'(a_addr % BLK_WORDS);
  assign a_set    = SET_W'((a_addr / BLK_WORDS) % SETS);
  assign a_tag    = TAG_W'(a_addr / (BLK_WORDS * SETS));
  assign cnt_last = (int'(cnt) == BLK_WORDS - 1);

  assign cmd_fire = mem_cmd_valid && mem_cmd_ready;
  assign wd_fire  = mem_wd_valid && mem_wd_ready;
  assign rd_fire  = mem_rd_valid && mem_rd_ready;

  // During lookup the requested victim is probed; afterwards the chosen way.
  assign sel_way = (state == ST_LOOKUP) ? a_way : tgt_q;

  wcd_tag_store #(
    .SETS (SETS),
    .WAYS (WAYS),
    .TAG_W(TAG_W),
    .SET_W(SET_W),
    .WAY_W(WAY_W)
  ) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (a_set),
    .tag_i      (a_tag),
    .sel_way_i  (sel_way),
    .hit_o      (hit),
    .hit_way_o  (hit_way),
    .sel_valid_o(sel_valid),
    .sel_dirty_o(sel_dirty),
    .sel_tag_o  (sel_tag),
    .wr_en_i    (tw_en),
    .wr_way_i   (tgt_q),
    .wr_tag_i   (a_tag),
    .wr_dirty_i (tw_dirty)
  );

  // Tag update: fill completion installs a clean line, a store marks policy dirtiness.
  assign tw_en    = (state == ST_FILL && rd_fire && cnt_last) || (state == ST_ACCESS && a_we);
  assign tw_dirty = (state == ST_ACCESS) && wback_en;

  assign rd_off  = (state == ST_ACCESS) ? a_off : cnt;
  assign dw_en   = (state == ST_FILL && rd_fire) || (state == ST_ACCESS && a_we);
  assign dw_off  = (state == ST_FILL) ? cnt : a_off;
  assign dw_word = (state == ST_FILL) ? mem_rd_data : a_wdata;

  wcd_data_store #(
    .SETS  (SETS),
    .WAYS  (WAYS),
    .BLK   (BLK_WORDS),
    .WORD_W(WORD_W),
    .SET_W (SET_W),
    .WAY_W (WAY_W),
    .OFF_W (OFF_W)
  ) u_data (
    .clk      (clk),
    .set_i    (a_set),
    .rd_way_i (tgt_q),
    .rd_off_i (rd_off),
    .rd_word_o(rd_word),
    .wr_en_i  (dw_en),
    .wr_way_i (tgt_q),
    .wr_off_i (dw_off),
    .wr_word_i(dw_word)
  );

  // Memory-side stream control
  always_comb begin
    mem_cmd_valid = 1'b0;
    mem_cmd_we    = 1'b0;
    mem_cmd_addr  = block_base(a_tag, a_set);
    mem_wd_valid  = 1'b0;
    mem_rd_ready  = 1'b0;
    unique case (state)
      ST_WBACK: begin
        mem_cmd_valid = !cmd_sent;
        mem_cmd_we    = 1'b1;
        mem_cmd_addr  = block_base(sel_tag, a_set);
        mem_wd_valid  = cmd_sent;
      end
      ST_FILL: begin
        mem_cmd_valid = !cmd_sent;
        mem_rd_ready  = cmd_sent;
      end
      ST_MWRITE: begin
        mem_cmd_valid = !cmd_sent;
        mem_cmd_we    = 1'b1;
        mem_wd_valid  = cmd_sent;
      end
      default: ;
    endcase
  end

  assign mem_wd_data = rd_word;
  assign req_ready   = (state == ST_IDLE);
  assign rsp_done    = done_q;
  assign rsp_rdata   = rdata_q;

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      a_addr   <= '0;
      a_we     <= 1'b0;
      a_wdata  <= '0;
      a_way    <= '0;
      tgt_q    <= '0;
      cnt      <= '0;
      cmd_sent <= 1'b0;
      done_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            a_addr  <= req_addr;
            a_we    <= req_we;
            a_wdata <= req_wdata;
            a_way   <= req_way;
            state   <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          cnt      <= '0;
          cmd_sent <= 1'b0;
          if (hit) begin
            tgt_q <= hit_way;
            state <= ST_ACCESS;
          end else begin
            tgt_q <= a_way;
            if (wback_en && sel_valid && sel_dirty) state <= ST_WBACK;
            else if (a_we && ONE_WORD)              state <= ST_ACCESS;
            else                                    state <= ST_FILL;
          end
        end
        ST_WBACK: begin
          if (cmd_fire) cmd_sent <= 1'b1;
          if (wd_fire) begin
            if (cnt_last) begin
              cnt      <= '0;
              cmd_sent <= 1'b0;
              state    <= (a_we && ONE_WORD) ? ST_ACCESS : ST_FILL;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_FILL: begin
          if (cmd_fire) cmd_sent <= 1'b1;
          if (rd_fire) begin
            if (cnt_last) begin
              cnt      <= '0;
              cmd_sent <= 1'b0;
              state    <= ST_ACCESS;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_ACCESS: begin
          if (!a_we) begin
            rdata_q <= rd_word;
            done_q  <= 1'b1;
            state   <= ST_IDLE;
          end else if (wback_en) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            cnt      <= '0;
            cmd_sent <= 1'b0;
            state    <= ST_MWRITE;
          end
        end
        ST_MWRITE: begin
          if (cmd_fire) cmd_sent <= 1'b1;
          if (wd_fire) begin
            if (cnt_last) begin
              cnt      <= '0;
              cmd_sent <= 1'b0;
              done_q   <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wcd_dcache_checks.sv
module wcd_dcache_checks #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              mem_cmd_valid,
  input logic              mem_cmd_ready,
  input logic              mem_cmd_we,
  input logic [ADDR_W-1:0] mem_cmd_addr,
  input logic              mem_wd_valid,
  input logic              mem_wd_ready,
  input logic [WORD_W-1:0] mem_wd_data,
  input logic              mem_rd_ready
);

  // R1: an idle controller drives no memory activity
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_cmd_valid && !mem_wd_valid && !mem_rd_ready));

  // R2: completion is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R2: an accepted request is not completed in the next cycle and blocks new ones
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !rsp_done));

  // R12: command held until accepted
  p_cmd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && !mem_cmd_ready) |=>
      (mem_cmd_valid && $stable(mem_cmd_we) && $stable(mem_cmd_addr)));

  // R12: write beat held until accepted
  p_wd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wd_valid && !mem_wd_ready) |=> (mem_wd_valid && $stable(mem_wd_data)));

  // R12: write stream and read readiness are exclusive
  p_one_stream_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wd_valid, mem_rd_ready}));

endmodule

bind wcd_dcache wcd_dcache_checks #(
  .ADDR_W(ADDR_W),
  .WORD_W(WORD_W)
) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_done     (rsp_done),
  .mem_cmd_valid(mem_cmd_valid),
  .mem_cmd_ready(mem_cmd_ready),
  .mem_cmd_we   (mem_cmd_we),
  .mem_cmd_addr (mem_cmd_addr),
  .mem_wd_valid (mem_wd_valid),
  .mem_wd_ready (mem_wd_ready),
  .mem_wd_data  (mem_wd_data),
  .mem_rd_ready (mem_rd_ready)
);

// File: tb/wcd_mem_model.sv
module wcd_mem_model #(
  parameter int AW  = 8,
  parameter int DW  = 32,
  parameter int BLK = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_we,
  input  logic [AW-1:0] cmd_addr,
  input  logic          wd_valid,
  output logic          wd_ready,
  input  logic [DW-1:0] wd_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output int            rd_cmds,
  output int            wr_cmds,
  output int            wr_beats
);

  logic [DW-1:0] mem [2**AW];
  logic [1:0]    phase;
  logic [1:0]    tick;
  logic [AW-1:0] base;
  logic [AW-1:0] beat;

  // Periodic stalls on every stream
  assign cmd_ready = (phase == 2'd0) && (tick != 2'd3);
  assign wd_ready  = (phase == 2'd1) && (tick != 2'd1);
  assign rd_valid  = (phase == 2'd2) && (tick != 2'd2);
  assign rd_data   = mem[base + beat];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= 2'd0;
      tick     <= 2'd0;
      base     <= '0;
      beat     <= '0;
      rd_cmds  <= 0;
      wr_cmds  <= 0;
      wr_beats <= 0;
      for (int i = 0; i < 2**AW; i++) mem[AW'(i)] <= DW'(32'h5A00_0000 + 32'(i * 7));
    end else begin
      tick <= tick + 2'd1;
      if (cmd_valid && cmd_ready) begin
        base  <= cmd_addr;
        beat  <= '0;
        phase <= cmd_we ? 2'd1 : 2'd2;
        if (cmd_we) wr_cmds <= wr_cmds + 1;
        else        rd_cmds <= rd_cmds + 1;
      end
      if (wd_valid && wd_ready) begin
        mem[base + beat] <= wd_data;
        wr_beats <= wr_beats + 1;
        beat <= beat + 1'b1;
        if (int'(beat) == BLK - 1) phase <= 2'd0;
      end
      if (rd_valid && rd_ready) begin
        beat <= beat + 1'b1;
        if (int'(beat) == BLK - 1) phase <= 2'd0;
      end
    end
  end

endmodule

// File: tb/wcd_dcache_test.sv
`timescale 1ns/1ps
module wcd_dcache_test;

  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wbm = 1'b0;
  logic v0 = 1'b0;
  logic v1 = 1'b0;
  logic r_we = 1'b0;
  logic [AW-1:0] r_addr = '0;
  logic [DW-1:0] r_wdata = '0;
  logic [0:0] r_way = '0;

  logic rdy0, rdy1, done0, done1;
  logic [DW-1:0] rdat0, rdat1;
  logic cv0, cr0, cw0, wv0, wr0, rv0, rr0;
  logic cv1, cr1, cw1, wv1, wr1, rv1, rr1;
  logic [AW-1:0] ca0, ca1;
  logic [DW-1:0] wd0, wd1, rdd0, rdd1;
  int rc0, wc0, wb0, rc1, wc1, wb1;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  wcd_dcache #(.ADDR_W(AW), .WORD_W(DW), .SETS(4), .WAYS(2), .BLK_WORDS(4)) uut (
    .clk(clk), .rst_n(rst_n), .wback_en(wbm),
    .req_valid(v0), .req_ready(rdy0), .req_we(r_we), .req_addr(r_addr),
    .req_wdata(r_wdata), .req_way(r_way), .rsp_done(done0), .rsp_rdata(rdat0),
    .mem_cmd_valid(cv0), .mem_cmd_ready(cr0), .mem_cmd_we(cw0), .mem_cmd_addr(ca0),
    .mem_wd_valid(wv0), .mem_wd_ready(wr0), .mem_wd_data(wd0),
    .mem_rd_valid(rv0), .mem_rd_ready(rr0), .mem_rd_data(rdd0));

  wcd_dcache #(.ADDR_W(AW), .WORD_W(DW), .SETS(4), .WAYS(2), .BLK_WORDS(1)) uut1 (
    .clk(clk), .rst_n(rst_n), .wback_en(wbm),
    .req_valid(v1), .req_ready(rdy1), .req_we(r_we), .req_addr(r_addr),
    .req_wdata(r_wdata), .req_way(r_way), .rsp_done(done1), .rsp_rdata(rdat1),
    .mem_cmd_valid(cv1), .mem_cmd_ready(cr1), .mem_cmd_we(cw1), .mem_cmd_addr(ca1),
    .mem_wd_valid(wv1), .mem_wd_ready(wr1), .mem_wd_data(wd1),
    .mem_rd_valid(rv1), .mem_rd_ready(rr1), .mem_rd_data(rdd1));

  wcd_mem_model #(.AW(AW), .DW(DW), .BLK(4)) mem0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cv0), .cmd_ready(cr0), .cmd_we(cw0),
    .cmd_addr(ca0), .wd_valid(wv0), .wd_ready(wr0), .wd_data(wd0),
    .rd_valid(rv0), .rd_ready(rr0), .rd_data(rdd0),
    .rd_cmds(rc0), .wr_cmds(wc0), .wr_beats(wb0));

  wcd_mem_model #(.AW(AW), .DW(DW), .BLK(1)) mem1 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cv1), .cmd_ready(cr1), .cmd_we(cw1),
    .cmd_addr(ca1), .wd_valid(wv1), .wd_ready(wr1), .wd_data(wd1),
    .rd_valid(rv1), .rd_ready(rr1), .rd_data(rdd1),
    .rd_cmds(rc1), .wr_cmds(wc1), .wr_beats(wb1));

  // Reference state derived from the requirements
  logic [DW-1:0] smem [256];
  bit rvalid [2][4][2];
  bit rdirty [2][4][2];
  int rtag   [2][4][2];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic ref_reset();
    for (int a = 0; a < 256; a++) smem[a] = 32'h5A00_0000 + 32'(a * 7);
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 2; w++) begin
          rvalid[d][s][w] = 1'b0;
          rdirty[d][s][w] = 1'b0;
          rtag[d][s][w]   = 0;
        end
  endtask

  task automatic do_access(input bit we, input int addr, input int data, input int way);
    int    exp_rd [2];
    int    exp_wr [2];
    string tg [2];
    int    rc_b [2];
    int    wc_b [2];
    logic [DW-1:0] exp_data;
    logic [DW-1:0] got_data [2];
    bit    got0, got1, a0, a1;
    for (int d = 0; d < 2; d++) begin
      int b, s, t, hw;
      bit ev, fill;
      b  = (d == 0) ? 4 : 1;
      s  = (addr / b) % 4;
      t  = addr / (b * 4);
      hw = -1;
      for (int w = 0; w < 2; w++) if (rvalid[d][s][w] && rtag[d][s][w] == t) hw = w;
      if (hw >= 0) begin
        exp_rd[d] = 0;
        exp_wr[d] = (we && !wbm) ? 1 : 0;
        tg[d] = !we ? ((hw != way) ? "R11" : "R3") : (wbm ? "R7" : "R5");
        if (we && wbm) rdirty[d][s][hw] = 1'b1;
      end else begin
        ev   = wbm && rvalid[d][s][way] && rdirty[d][s][way];
        fill = !(we && b == 1);
        exp_rd[d] = fill ? 1 : 0;
        exp_wr[d] = (ev ? 1 : 0) + ((we && !wbm) ? 1 : 0);
        tg[d] = (b == 1 && we) ? "R10" : ev ? "R8" : wbm ? "R9" : we ? "R6" : "R4";
        rvalid[d][s][way] = 1'b1;
        rtag[d][s][way]   = t;
        rdirty[d][s][way] = we && wbm;
      end
    end
    rc_b[0] = rc0; wc_b[0] = wc0; rc_b[1] = rc1; wc_b[1] = wc1;
    exp_data = smem[addr];
    if (we) smem[addr] = 32'(data);

    r_we = we; r_addr = AW'(addr); r_wdata = 32'(data); r_way = 1'(way);
    v0 = 1'b1; v1 = 1'b1;
    got0 = 1'b0; got1 = 1'b0;
    while (!(got0 && got1)) begin
      a0 = v0 && rdy0;
      a1 = v1 && rdy1;
      @(negedge clk);
      if (a0) v0 = 1'b0;
      if (a1) v1 = 1'b0;
      if (done0) begin
        chk(!got0, "R2", "single done pulse (blk4)", 1, 0);
        chk(rdy0, "R2", "ready during done (blk4)", rdy0, 1);
        got0 = 1'b1; got_data[0] = rdat0;
      end
      if (done1) begin
        chk(!got1, "R2", "single done pulse (blk1)", 1, 0);
        chk(rdy1, "R2", "ready during done (blk1)", rdy1, 1);
        got1 = 1'b1; got_data[1] = rdat1;
      end
    end

    chk(rc0 - rc_b[0] == exp_rd[0], tg[0], "read cmds blk4", rc0 - rc_b[0], exp_rd[0]);
    chk(wc0 - wc_b[0] == exp_wr[0], tg[0], "write cmds blk4", wc0 - wc_b[0], exp_wr[0]);
    chk(rc1 - rc_b[1] == exp_rd[1], tg[1], "read cmds blk1", rc1 - rc_b[1], exp_rd[1]);
    chk(wc1 - wc_b[1] == exp_wr[1], tg[1], "write cmds blk1", wc1 - wc_b[1], exp_wr[1]);
    if (!we) begin
      chk(got_data[0] == exp_data, tg[0], "load data blk4", got_data[0], exp_data);
      chk(got_data[1] == exp_data, tg[1], "load data blk1", got_data[1], exp_data);
    end else if (!wbm) begin
      chk(mem0.mem[AW'(addr)] == 32'(data), tg[0], "memory word blk4", mem0.mem[AW'(addr)], 32'(data));
      chk(mem1.mem[AW'(addr)] == 32'(data), tg[1], "memory word blk1", mem1.mem[AW'(addr)], 32'(data));
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      wbm   = p[0];
      rst_n = 1'b0;
      v0 = 1'b0; v1 = 1'b0;
      ref_reset();
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(rdy0 && rdy1, "R1", "ready in reset", {rdy0, rdy1}, 2'b11);
      chk(!done0 && !done1, "R1", "done in reset", {done0, done1}, 0);
      chk(!cv0 && !cv1 && !wv0 && !wv1 && !rr0 && !rr1, "R1", "memory idle in reset",
          {cv0, cv1, wv0, wv1, rr0, rr1}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // Directed: same block twice through different ways (R11), then a conflict sweep
      do_access(1'b0, 5, 0, 0);
      do_access(1'b0, 5, 0, 1);
      do_access(1'b1, 6, 32'h1234_0000 + p, 1);
      do_access(1'b0, 6, 0, 0);
      for (int i = 0; i < 180; i++) begin
        int addr, way, data;
        bit we;
        addr = (i * 13 + (i / 7) * 3) % 48;
        way  = (i / 3) % 2;
        we   = (i % 4 == 1) || (i % 4 == 2);
        data = 32'hC0DE_0000 + i * 17 + p * 1000;
        do_access(we, addr, data, way);
      end
      // Final sweep: every word reads back its latest value, including evicted ones
      for (int a = 0; a < 48; a++) do_access(1'b0, a, 0, a % 2);
      // R12: every write command carried a full line of beats despite stalls
      chk(wb0 == 4 * wc0, "R12", "write beats per line blk4", wb0, 4 * wc0);
      chk(wb1 == wc1, "R12", "write beats per line blk1", wb1, wc1);
    end
    finish_run();
  end

endmodule